// File: doc/BRIEF.md
# Single-Lane Serial Flash Command Shifter

This block sends a software-built, single-lane SPI sequence to a serial flash and keeps the bytes the flash returns. Software fills six transmit byte registers, sets a total clock count of up to 56, and optionally turns on one extra sampling cycle. Writing the start bit in the control register launches the transaction. The engine drives chip select and the serial clock in mode 0 and shifts the transmit bytes out MSB first, beginning with the highest-indexed register. It samples the returned line on each rising clock edge and stores every complete byte in a ten-deep receive bank. The newest byte goes to slot 0 and older bytes move up.

The start bit reads back as 1 while the engine runs and drops to 0 when it finishes, so software can poll it. The same cycle-accurate completion also appears as a one-cycle `done_o` pulse. Register accesses use a simple byte-wide bus with a write strobe and a combinational read path.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, `cs_no` is 1, `sck_o` is 0, `done_o` is 0, the control register (address 7) reads 0 and every receive byte (addresses 16 to 25) reads 0.
- R2: A bus write to address 7 with bit 2 set, made while idle, starts a transaction. Bit 2 of address 7 reads 1 until the transaction ends and reads 0 afterwards, and `done_o` is high for exactly one clock per transaction.
- R3: Transmit bytes sit at addresses 0 to 5. `mosi_o` carries byte 5 first, then 4 down to 0, each MSB first and valid at each rising `sck_o`. Any bits past the 48th are 0. The number of rising `sck_o` edges equals the stored count (plus one when R6 is on).
- R4: The count register at address 6 stores the written byte, saturated to 56, and reads back the stored value.
- R5: `miso_i` is sampled on each rising `sck_o`. Every 8 kept samples form one byte, MSB first, and push it into the receive bank: slot 0 gets the new byte and slot i gets the old slot i-1. A trailing partial byte is dropped. Slot i reads at address 16+i.
- R6: When bit 0 of address 8 is 1 and the count is nonzero, the transaction runs one extra `sck_o` cycle and the sample taken on the first rising edge is discarded.
- R7: A count of 0 completes with a `done_o` pulse, without lowering `cs_no` and without any `sck_o` edge.
- R8: While a transaction runs, every bus write is ignored, including another start. The running transaction and the stored registers are unchanged.
- R9: `sck_o` idles low and is only high while `cs_no` is low. `cs_no` falls 2*HALF_DIV clocks before the first rising `sck_o` and rises HALF_DIV clocks after the last falling `sck_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational on address) |
| sck_o | output | 1 | Serial clock, idle low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two things can meet in the same cycle: a second start or a register write, and the running sequencer that is still consuming the count and transmit state. The bench provokes this by re-issuing the start and overwriting the count and transmit byte 0 a few clocks into long transactions. It then judges the result by the clock-edge count, the captured serial stream and the register readback after completion. A second meeting point is the zero-count start. There the start and the completion fall back to back, and the bench checks that exactly one done pulse appears with the chip select never falling.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_FIN
  } seq_state_t;

  localparam int unsigned START_BIT = 2;
  localparam int unsigned EXTRA_BIT = 0;
endpackage

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs #(
  parameter int unsigned TX_BYTES = 6,
  parameter int unsigned RX_BYTES = 10,
  parameter int unsigned MAX_BITS = 56,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_wr_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [7:0]              bus_wdata_i,
  output logic [7:0]              bus_rdata_o,
  input  logic                    busy_i,
  input  logic [RX_BYTES*8-1:0]   rx_bank_i,
  output logic [TX_BYTES*8-1:0]   tx_flat_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    extra_o,
  output logic                    start_o
);
  import spi_cmd_pkg::*;

  localparam int unsigned ADDR_CNT  = TX_BYTES;
  localparam int unsigned ADDR_CTRL = TX_BYTES + 1;
  localparam int unsigned ADDR_CFG  = TX_BYTES + 2;
  localparam int unsigned ADDR_RX   = 2 ** (ADDR_W - 1);

  logic [7:0]       tx_q [TX_BYTES];
  logic [7:0]       tx_d [TX_BYTES];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             extra_q, extra_d;
  logic             wr_ok;

  assign wr_ok   = bus_wr_i && !busy_i;
  assign start_o = wr_ok && (bus_addr_i == ADDR_W'(ADDR_CTRL)) && bus_wdata_i[START_BIT];

  always_comb begin
    for (int i = 0; i < TX_BYTES; i++) tx_d[i] = tx_q[i];
    cnt_d   = cnt_q;
    extra_d = extra_q;
    if (wr_ok) begin
      for (int i = 0; i < TX_BYTES; i++)
        if (bus_addr_i == ADDR_W'(i)) tx_d[i] = bus_wdata_i;
      if (bus_addr_i == ADDR_W'(ADDR_CNT)) begin
        if (bus_wdata_i > 8'(MAX_BITS)) cnt_d = CNT_W'(MAX_BITS);
        else                            cnt_d = bus_wdata_i[CNT_W-1:0];
      end
      if (bus_addr_i == ADDR_W'(ADDR_CFG)) extra_d = bus_wdata_i[EXTRA_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TX_BYTES; i++) tx_q[i] <= '0;
      cnt_q   <= '0;
      extra_q <= 1'b0;
    end else begin
      for (int i = 0; i < TX_BYTES; i++) tx_q[i] <= tx_d[i];
      cnt_q   <= cnt_d;
      extra_q <= extra_d;
    end
  end

  for (genvar g = 0; g < TX_BYTES; g++) begin : g_txflat
    assign tx_flat_o[g*8 +: 8] = tx_q[g];
  end
  assign cnt_o   = cnt_q;
  assign extra_o = extra_q;

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < TX_BYTES; i++)
      if (bus_addr_i == ADDR_W'(i)) bus_rdata_o = tx_q[i];
    if (bus_addr_i == ADDR_W'(ADDR_CNT))  bus_rdata_o = 8'(cnt_q);
    if (bus_addr_i == ADDR_W'(ADDR_CTRL)) bus_rdata_o[START_BIT] = busy_i;
    if (bus_addr_i == ADDR_W'(ADDR_CFG))  bus_rdata_o[EXTRA_BIT] = extra_q;
    for (int i = 0; i < RX_BYTES; i++)
      if (bus_addr_i == ADDR_W'(ADDR_RX + i)) bus_rdata_o = rx_bank_i[i*8 +: 8];
  end

  // R4
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_BITS));

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(cnt_q) && $stable(tx_q[0]) && $stable(extra_q)));
endmodule

// File: rtl/spi_cmd_seq.sv
`timescale 1ns/1ps
module spi_cmd_seq #(
  parameter int unsigned TX_BYTES = 6,
  parameter int unsigned MAX_BITS = 56,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  extra_i,
  input  logic [TX_BYTES*8-1:0] tx_flat_i,
  output logic                  sck_o,
  output logic                  cs_no,
  output logic                  mosi_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  sample_o
);
  import spi_cmd_pkg::*;

  localparam int unsigned TX_W     = TX_BYTES * 8;
  localparam int unsigned STREAM_W = MAX_BITS + 1;
  localparam int unsigned DIV_W    = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;

  seq_state_t            state_q, state_d;
  logic [DIV_W-1:0]      div_q, div_d;
  logic [CNT_W-1:0]      bit_q, bit_d, total_q, total_d, bit_nx;
  logic                  skip_q, skip_d;
  logic [STREAM_W-1:0]   sr_q, sr_d;
  logic                  sck_q, sck_d, cs_q, cs_d;
  logic                  stb;

  assign bit_nx = bit_q + CNT_W'(1);

  always_comb begin
    state_d = state_q;
    div_d   = div_q;
    bit_d   = bit_q;
    total_d = total_q;
    skip_d  = skip_q;
    sr_d    = sr_q;
    sck_d   = sck_q;
    cs_d    = cs_q;
    stb     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (cnt_i == '0) begin
          state_d = ST_FIN;
        end else begin
          state_d = ST_LEAD;
          cs_d    = 1'b0;
          div_d   = DIV_W'(2 * HALF_DIV - 1);
          bit_d   = '0;
          total_d = cnt_i + CNT_W'(extra_i);
          skip_d  = extra_i;
          sr_d    = {tx_flat_i, {(STREAM_W - TX_W){1'b0}}};
        end
      end
      ST_LEAD, ST_LOW: begin
        if (div_q == '0) begin
          state_d = ST_HIGH;
          sck_d   = 1'b1;
          stb     = 1'b1;
          div_d   = DIV_W'(HALF_DIV - 1);
        end else begin
          div_d = div_q - DIV_W'(1);
        end
      end
      ST_HIGH: begin
        if (div_q == '0) begin
          sck_d = 1'b0;
          bit_d = bit_nx;
          div_d = DIV_W'(HALF_DIV - 1);
          if (bit_nx == total_q) begin
            state_d = ST_TAIL;
          end else begin
            state_d = ST_LOW;
            sr_d    = {sr_q[STREAM_W-2:0], 1'b0};
          end
        end else begin
          div_d = div_q - DIV_W'(1);
        end
      end
      ST_TAIL: begin
        if (div_q == '0) begin
          cs_d    = 1'b1;
          state_d = ST_FIN;
        end else begin
          div_d = div_q - DIV_W'(1);
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      total_q <= '0;
      skip_q  <= 1'b0;
      sr_q    <= '0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
      total_q <= total_d;
      skip_q  <= skip_d;
      sr_q    <= sr_d;
      sck_q   <= sck_d;
      cs_q    <= cs_d;
    end
  end

  assign sck_o    = sck_q;
  assign cs_no    = cs_q;
  assign mosi_o   = sr_q[STREAM_W-1];
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);
  assign sample_o = stb && !(skip_q && (bit_q == '0));

  // R9
  idle_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> cs_q);

  // R9
  sck_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> !cs_q);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R7
  zero_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (cnt_i == '0)) |=> (done_o && cs_q && !sck_q));
endmodule

// File: rtl/spi_cmd_rxbank.sv
`timescale 1ns/1ps
module spi_cmd_rxbank #(
  parameter int unsigned RX_BYTES = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  sample_i,
  input  logic                  miso_i,
  output logic [RX_BYTES*8-1:0] bank_o
);
  logic [6:0] sr_q, sr_d;
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] bank_q [RX_BYTES];
  logic [7:0] bank_d [RX_BYTES];
  logic       push;

  assign push = sample_i && (cnt_q == 3'd7);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    for (int i = 0; i < RX_BYTES; i++) bank_d[i] = bank_q[i];
    if (clr_i) begin
      cnt_d = '0;
    end else if (sample_i) begin
      sr_d  = {sr_q[5:0], miso_i};
      cnt_d = cnt_q + 3'd1;
      if (push) begin
        bank_d[0] = {sr_q, miso_i};
        for (int i = 1; i < RX_BYTES; i++) bank_d[i] = bank_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < RX_BYTES; i++) bank_q[i] <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      for (int i = 0; i < RX_BYTES; i++) bank_q[i] <= bank_d[i];
    end
  end

  for (genvar g = 0; g < RX_BYTES; g++) begin : g_flat
    assign bank_o[g*8 +: 8] = bank_q[g];
  end

  // R5
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(bank_o));
endmodule

// File: rtl/spi_cmd_shifter.sv
`timescale 1ns/1ps
module spi_cmd_shifter #(
  parameter int unsigned TX_BYTES = 6,
  parameter int unsigned RX_BYTES = 10,
  parameter int unsigned MAX_BITS = 56,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              done_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BITS + 2);

  logic                  rst_s1, rst_n;
  logic                  busy, start, extra, sample;
  logic [CNT_W-1:0]      cnt;
  logic [TX_BYTES*8-1:0] tx_flat;
  logic [RX_BYTES*8-1:0] rx_bank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1 <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_n  <= rst_s1;
    end
  end

  spi_cmd_regs #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .MAX_BITS(MAX_BITS),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) regs_i (
    .clk_i(clk_i), .rst_ni(rst_n),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .busy_i(busy), .rx_bank_i(rx_bank),
    .tx_flat_o(tx_flat), .cnt_o(cnt), .extra_o(extra), .start_o(start)
  );

  spi_cmd_seq #(
    .TX_BYTES(TX_BYTES), .MAX_BITS(MAX_BITS), .HALF_DIV(HALF_DIV), .CNT_W(CNT_W)
  ) seq_i (
    .clk_i(clk_i), .rst_ni(rst_n), .start_i(start), .cnt_i(cnt),
    .extra_i(extra), .tx_flat_i(tx_flat), .sck_o(sck_o), .cs_no(cs_no),
    .mosi_o(mosi_o), .busy_o(busy), .done_o(done_o), .sample_o(sample)
  );

  spi_cmd_rxbank #(.RX_BYTES(RX_BYTES)) rx_i (
    .clk_i(clk_i), .rst_ni(rst_n), .clr_i(start), .sample_i(sample),
    .miso_i(miso_i), .bank_o(rx_bank)
  );
endmodule

// File: tb/spi_cmd_shifter_tb.sv
`timescale 1ns/1ps
module spi_cmd_shifter_tb_top;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, cs_n, mosi, done;
  logic       miso = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spi_cmd_shifter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sck_o(sck), .cs_no(cs_n),
    .mosi_o(mosi), .miso_i(miso), .done_o(done)
  );

  logic [63:0] pat = '0;
  logic [63:0] mosi_cap;
  int cyc = 0, edges, kidx, cs_falls, done_cnt;
  int cs_fall_cyc, rise1_cyc, last_fall_cyc, cs_rise_cyc;
  logic sck_prev = 1'b0, cs_prev = 1'b1;
  logic [7:0] model [10];

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && cs_prev) begin
      cs_fall_cyc = cyc; cs_falls++; kidx = 0; miso = pat[63];
    end
    if (sck && !sck_prev) begin
      if (edges == 0) rise1_cyc = cyc;
      edges++;
      mosi_cap = {mosi_cap[62:0], mosi};
    end
    if (!sck && sck_prev) begin
      last_fall_cyc = cyc;
      kidx++;
      if (kidx < 64) miso = pat[63-kidx];
    end
    if (cs_n && !cs_prev) cs_rise_cyc = cyc;
    if (done) done_cnt++;
    sck_prev = sck;
    cs_prev  = cs_n;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 5'(a);
    #1 d = rdata;
  endtask

  task automatic run_xfer(input logic [47:0] txw, input int cnt_w, input bit ext,
                          input logic [63:0] p, input bit poke);
    logic [7:0] r;
    int exp_cnt, t, nb, guard;
    logic [63:0] stream, exp_mosi;
    for (int i = 0; i < 6; i++) bus_write(i, txw[i*8 +: 8]);
    bus_write(6, 8'(cnt_w));
    bus_write(8, {7'd0, ext});
    exp_cnt = (cnt_w > 56) ? 56 : cnt_w;
    bus_read(6, r);
    chk(r == 8'(exp_cnt), "R4 count readback", 64'(r), 64'(exp_cnt));
    pat = p; edges = 0; mosi_cap = '0; done_cnt = 0; cs_falls = 0;
    bus_write(7, 8'h04);
    if (poke) begin
      repeat (3) @(negedge clk);
      bus_write(7, 8'h04);
      bus_write(6, 8'd3);
      bus_write(0, ~txw[7:0]);
    end
    guard = 0;
    do begin
      bus_read(7, r);
      guard++;
    end while (r[2] && guard < 5000);
    repeat (3) @(negedge clk);
    chk(r[2] == 1'b0, "R2 start bit cleared", 64'(r), 64'(0));
    t = (exp_cnt == 0) ? 0 : exp_cnt + int'(ext);
    stream = {txw[47:40], txw[39:32], txw[31:24], txw[23:16], txw[15:8], txw[7:0], 16'h0};
    exp_mosi = (t == 0) ? 64'h0 : (stream >> (64 - t));
    chk(edges == t, "R3/R6 sck edge count", 64'(edges), 64'(t));
    chk(mosi_cap == exp_mosi, "R3 mosi stream", mosi_cap, exp_mosi);
    chk(done_cnt == 1, "R2 done pulse count", 64'(done_cnt), 64'(1));
    if (t == 0) begin
      chk(cs_falls == 0, "R7 cs held high on zero count", 64'(cs_falls), 64'(0));
    end else begin
      chk(rise1_cyc - cs_fall_cyc == 2*HALF, "R9 cs lead", 64'(rise1_cyc - cs_fall_cyc), 64'(2*HALF));
      chk(cs_rise_cyc - last_fall_cyc == HALF, "R9 cs tail", 64'(cs_rise_cyc - last_fall_cyc), 64'(HALF));
    end
    nb = exp_cnt / 8;
    for (int j = 0; j < nb; j++) begin
      logic [63:0] sh;
      for (int i = 9; i > 0; i--) model[i] = model[i-1];
      sh = p >> (56 - int'(ext) - 8*j);
      model[0] = sh[7:0];
    end
    for (int i = 0; i < 10; i++) begin
      bus_read(16 + i, r);
      chk(r == model[i], ext ? "R6 rx bank with extra cycle" : "R5 rx bank", 64'(r), 64'(model[i]));
    end
    if (poke) begin
      bus_read(6, r);
      chk(r == 8'(exp_cnt), "R8 count write ignored while busy", 64'(r), 64'(exp_cnt));
      bus_read(0, r);
      chk(r == txw[7:0], "R8 tx write ignored while busy", 64'(r), 64'(txw[7:0]));
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 10; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0 && done == 1'b0, "R1 pin reset state",
        64'({cs_n, sck, done}), 64'(3'b100));
    bus_read(7, r);
    chk(r == 8'h00, "R1 control reset", 64'(r), 64'(0));
    for (int i = 0; i < 10; i++) begin
      bus_read(16 + i, r);
      chk(r == 8'h00, "R1 rx bank reset", 64'(r), 64'(0));
    end
    // directed corners
    run_xfer(48'h0B_A1_B2_C3_D4_E5, 8, 1'b0, 64'hA5C3_0F00_1122_3344, 1'b0);
    run_xfer(48'h9F_00_00_00_00_00, 0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);   // R7
    run_xfer(48'h03_12_34_56_00_00, 56, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0); // R6 at max
    run_xfer(48'h05_00_00_00_00_00, 13, 1'b0, 64'hC0DE_0000_0000_0000, 1'b0); // R5 partial byte
    run_xfer(48'h01_02_03_04_05_06, 200, 1'b0, 64'h0102_0408_1020_4080, 1'b0); // R4 saturation
    run_xfer(48'h6B_FE_DC_BA_98_76, 48, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 1'b1); // R8
    // random mix
    for (int n = 0; n < 20; n++) begin
      logic [47:0] tw;
      logic [63:0] pw;
      tw = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
      pw = {$urandom(), $urandom()};
      run_xfer(tw, int'($urandom() % 64), 1'($urandom()), pw, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule